// File: doc/BRIEF.md
# Byte-Register SPI Master

A single-clock SPI master that a host drives through seven byte-wide registers. The host writes a byte to the data address. The byte enters a transmit queue, and the shift engine moves it out on `mosi` MSB first while it takes in eight bits from `miso`. The received byte then goes into a receive queue. Software polls the receive-empty status bit until it drops, then reads the byte from the same data address. Reading that address also removes the byte from the queue.

The serial clock rate comes from a 4-bit rate code. Its low half sits in the control register and its high half in the extended register. The codes map to power-of-two divide ratios in a permuted order. Clock polarity and clock phase give the four usual SPI modes. Four active-low chip selects are driven by software. Each line has a take-over bit and a level bit in one register. A parameter bit that selects memory-mapped reading is kept as storage only. While that bit is set, it blocks register-driven transfers.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, status reads 0x01, every other register reads 0x00, `cs_n` is 4'hF and `sck` is 0.
- R2: Register map by `reg_addr`: 0 control (bit 6 core enable, bit 3 polarity, bit 2 phase, bits 1:0 rate code low half), 1 status, 2 data, 3 extended (bits 1:0 rate code high half), 4 parameter (bit 0 memory-mapped read), 5 chip select (all 8 bits), 6 timing (all 8 bits). Unlisted bits and address 7 read 0.
- R3: Rate code {ext[1:0], ctl[1:0]} gives the divide ratio: 0→2, 1→4, 4→8, 2→16, 3→32, 5→64, 6→128, 7→256, 8→512, 9→1024, 10→2048, 11→4096. Codes 12 to 15 give 4096. A byte written at clock edge 0 makes receive-empty drop after edge 1+8·ratio.
- R4: Each byte is 8 bits, MSB first. `sck` rests at the polarity level between transfers. With phase 0, `miso` is sampled on the 1st, 3rd, … `sck` edges. With phase 1, it is sampled on the 2nd, 4th, … edges. `mosi` changes only on the other edges.
- R5: Status bit 0 reads 1 while the receive queue is empty. Reading address 2 returns the oldest received byte and removes it, or returns 0x00 if the queue is empty.
- R6: Status bit 7 sets when a byte completes. Status bit 6 is the write-collision flag. Writing 1 to either bit clears it, and writing 0 leaves it unchanged.
- R7: Each queue holds 4 bytes. A data write while 4 bytes are waiting to transmit sets the write-collision flag and discards the byte.
- R8: No transfer starts while the receive queue is full, so no received byte is lost. Transfers resume once software reads a byte out.
- R9: Chip-select register bit n (n=0..3) hands line n to software, and bit n+4 is its level: `cs_n[n]` = bit n ? bit n+4 : 1. Writing 0 releases all four lines high.
- R10: Clearing core enable aborts a transfer in progress, returns `sck` to its rest level and empties both queues. Data writes while the core is disabled are discarded.
- R11: While parameter bit 0 is set, data writes are discarded and no transfer starts.
- R12: The timing register only stores its value and has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (removes a byte when addressing data) |
| reg_rdata | output | 8 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions take for granted that the write and read strobes are single-cycle pulses and that `reg_addr` is steady while a strobe is high. They also assume `miso` is stable at the core clock edge where the engine samples it. The bench drives every strobe for exactly one cycle from the falling clock edge. Its slave model moves `miso` only after a serial clock edge that the master has already registered. This keeps each sampled bit settled for a full half period.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DEPTH = 4,
  parameter int DIVW  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic [3:0] cs_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [2:0] A_CTL = 3'd0, A_STS = 3'd1, A_DAT = 3'd2, A_EXT = 3'd3,
                         A_PAR = 3'd4, A_CS  = 3'd5, A_TMG = 3'd6;

  logic            ctl_en, cpol, cpha, map_en, flag_done, flag_wcol;
  logic [1:0]      rate_lo, rate_hi;
  logic [7:0]      cs_reg, tmg;
  logic [7:0]      tx_mem [DEPTH];
  logic [7:0]      rx_mem [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            busy, tog;
  logic [3:0]      edge_no;
  logic [DIVW-1:0] div_cnt, half_m1;
  logic [7:0]      out_sh, in_sh, nxt_in;
  logic [3:0]      lg;

  wire wr_dat   = reg_wr && reg_addr == A_DAT;
  wire wr_sts   = reg_wr && reg_addr == A_STS;
  wire tx_full  = tx_cnt == FULL;
  wire rx_full  = rx_cnt == FULL;
  wire rx_empty = rx_cnt == '0;
  wire accept   = wr_dat && ctl_en && !map_en;
  wire push_tx  = accept && !tx_full;
  wire start    = ctl_en && !busy && !map_en && tx_cnt != '0 && !rx_full;
  wire step     = busy && div_cnt >= half_m1;
  wire smp      = cpha ? edge_no[0] : !edge_no[0];
  wire shf      = cpha ? (!edge_no[0] && edge_no != 4'd0) : edge_no[0];
  wire last     = step && edge_no == 4'd15;
  wire pop_rx   = reg_rd && reg_addr == A_DAT && !rx_empty;

  assign nxt_in = smp ? {in_sh[6:0], miso} : in_sh;
  assign sck    = cpol ^ tog;
  assign mosi   = out_sh[7];

  always_comb begin
    unique case ({rate_hi, rate_lo})
      4'd0:    lg = 4'd1;
      4'd1:    lg = 4'd2;
      4'd2:    lg = 4'd4;
      4'd3:    lg = 4'd5;
      4'd4:    lg = 4'd3;
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11: lg = {rate_hi, rate_lo} + 4'd1;
      default: lg = 4'd12;
    endcase
    half_m1 = (DIVW'(1) << (lg - 4'd1)) - DIVW'(1);
  end

  always_comb begin
    unique case (reg_addr)
      A_CTL:   reg_rdata = {1'b0, ctl_en, 2'b00, cpol, cpha, rate_lo};
      A_STS:   reg_rdata = {flag_done, flag_wcol, 5'b0, rx_empty};
      A_DAT:   reg_rdata = rx_empty ? 8'h00 : rx_mem[rx_rp];
      A_EXT:   reg_rdata = {6'b0, rate_hi};
      A_PAR:   reg_rdata = {7'b0, map_en};
      A_CS:    reg_rdata = cs_reg;
      A_TMG:   reg_rdata = tmg;
      default: reg_rdata = 8'h00;
    endcase
  end

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_n[i] = cs_reg[i] ? cs_reg[i+4] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_tx) tx_mem[tx_wp] <= reg_wdata;
    if (last)    rx_mem[rx_wp] <= nxt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; rate_lo <= '0; rate_hi <= '0;
      map_en <= 1'b0; cs_reg <= '0; tmg <= '0;
      flag_done <= 1'b0; flag_wcol <= 1'b0;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          A_CTL: begin
            ctl_en  <= reg_wdata[6];
            cpol    <= reg_wdata[3];
            cpha    <= reg_wdata[2];
            rate_lo <= reg_wdata[1:0];
          end
          A_EXT: rate_hi <= reg_wdata[1:0];
          A_PAR: map_en  <= reg_wdata[0];
          A_CS:  cs_reg  <= reg_wdata;
          A_TMG: tmg     <= reg_wdata;
          default: ;
        endcase
      end
      if (last)                              flag_done <= 1'b1;
      else if (wr_sts && reg_wdata[7])       flag_done <= 1'b0;
      if (accept && tx_full)                 flag_wcol <= 1'b1;
      else if (wr_sts && reg_wdata[6])       flag_wcol <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; tog <= 1'b0; edge_no <= '0; div_cnt <= '0;
      out_sh <= '0; in_sh <= '0;
    end else if (!ctl_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; tog <= 1'b0; edge_no <= '0; div_cnt <= '0;
    end else begin
      if (push_tx) tx_wp <= tx_wp + AW'(1);
      if (start)   tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(push_tx) - CW'(start);
      if (last)    rx_wp <= rx_wp + AW'(1);
      if (pop_rx)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(last) - CW'(pop_rx);
      if (start) begin
        busy    <= 1'b1;
        out_sh  <= tx_mem[tx_rp];
        in_sh   <= '0;
        div_cnt <= '0;
        edge_no <= '0;
        tog     <= 1'b0;
      end else if (step) begin
        div_cnt <= '0;
        tog     <= ~tog;
        edge_no <= edge_no + 4'd1;
        in_sh   <= nxt_in;
        if (shf)  out_sh <= {out_sh[6:0], 1'b0};
        if (last) busy <= 1'b0;
      end else if (busy) begin
        div_cnt <= div_cnt + DIVW'(1);
      end
    end
  end

  a_r7_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);

  a_r7_wcol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_wcol) |-> $past(wr_dat && tx_cnt == FULL));

  a_r5_rx_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_cnt == '0) |-> $past(busy));

  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (!busy && tx_cnt == '0 && rx_cnt == '0));

  a_r11_r8_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!map_en && rx_cnt != FULL));

  a_r4_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sck, mosi, miso;
  logic [3:0] cs_n;

  int n_chk = 0, n_bad = 0;
  int ec = 0;
  logic [7:0] cap = '0, sb = '0;
  logic cpha_m = 1'b0;

  always #4 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always @(posedge sck or negedge sck) begin
    if (cpha_m ? ec[0] : !ec[0]) cap <= {cap[6:0], mosi};
    ec <= ec + 1;
  end

  always_comb begin
    logic [3:0] e;
    logic [2:0] idx;
    e = ec[3:0];
    if (!cpha_m) idx = e[3:1];
    else         idx = (e == 4'd0) ? 3'd0 : 3'((e - 4'd1) >> 1);
    miso = sb[3'd7 - idx];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic arm(input logic [7:0] s);
    sb = s; ec = 0; cap = '0;
  endtask

  task automatic wait_rx(output int n);
    n = 0;
    while (n < 40000) begin
      @(posedge clk); n++;
      #2 reg_addr = 3'd1;
      #1 if (!reg_rdata[0]) break;
    end
  endtask

  function automatic int ratio_of(input int code);
    int lg;
    case (code)
      0: lg = 1; 1: lg = 2; 2: lg = 4; 3: lg = 5; 4: lg = 3;
      default: lg = (code <= 11) ? code + 1 : 12;
    endcase
    return 1 << lg;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, tx;
    int n, got;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, d); chk(d == 8'h01, "R1 status", d, 8'h01);
    rd(3'd0, d); chk(d == 8'h00, "R1 control", d, 0);
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(sck == 1'b0, "R1 sck", sck, 0);

    // R2 register map and unused bits
    wr(3'd0, 8'hFF); rd(3'd0, d); chk(d == 8'h4F, "R2 control", d, 8'h4F);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk(d == 8'h03, "R2 extended", d, 3);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk(d == 8'h01, "R2 parameter", d, 1);
    wr(3'd4, 8'h00);
    rd(3'd7, d); chk(d == 8'h00, "R2 addr7", d, 0);

    // R12 timing storage
    for (int v = 0; v < 256; v += 51) begin
      wr(3'd6, 8'(v)); rd(3'd6, d); chk(d == 8'(v), "R12 timing readback", d, v);
    end

    // R9 chip-select sweep
    for (int v = 0; v < 256; v++) begin
      logic [3:0] e;
      wr(3'd5, 8'(v));
      for (int i = 0; i < 4; i++) e[i] = v[i] ? v[i+4] : 1'b1;
      chk(cs_n == e, "R9 cs_n", cs_n, e);
    end
    wr(3'd5, 8'h00); chk(cs_n == 4'hF, "R9 release", cs_n, 4'hF);

    // R4 R5 mode sweep
    for (int m = 0; m < 4; m++) begin
      cpha_m = m[0];
      wr(3'd0, 8'h40 | 8'(m[1] << 3) | 8'(m[0] << 2));
      #2 chk(sck == m[1], "R4 rest level", sck, m[1]);
      for (int i = 0; i < 6; i++) begin
        tx = 8'((m * 53 + i * 29 + 8'h5A) & 8'hFF);
        arm(~tx ^ 8'(i * 7));
        wr(3'd2, tx);
        wait_rx(n);
        rd(3'd2, d);
        chk(d == sb, "R4 R5 received byte", d, sb);
        chk(cap == tx, "R4 mosi bits", cap, tx);
        chk(sck == m[1], "R4 rest after byte", sck, m[1]);
      end
      rd(3'd1, d); chk(d[0] == 1'b1, "R5 empty after pop", d[0], 1);
      rd(3'd2, d); chk(d == 8'h00, "R5 empty read", d, 0);
    end
    cpha_m = 1'b0;

    // R3 rate sweep, R12 timing register ignored
    wr(3'd6, 8'hFF);
    for (int c = 0; c <= 12; c++) begin
      wr(3'd3, 8'(c >> 2));
      wr(3'd0, 8'h40 | 8'(c & 3));
      arm(8'hC3);
      wr(3'd2, 8'h3C);
      wait_rx(n);
      chk(n == 1 + 8 * ratio_of(c), "R3 R12 transfer length", n, 1 + 8 * ratio_of(c));
      rd(3'd2, d); chk(d == 8'hC3, "R3 data", d, 8'hC3);
    end
    wr(3'd3, 8'h00); wr(3'd0, 8'h40);

    // R6 done flag, write-one-to-clear
    rd(3'd1, d); chk(d[7] == 1'b1, "R6 done set", d[7], 1);
    wr(3'd1, 8'h00); rd(3'd1, d); chk(d[7] == 1'b1, "R6 zero write", d[7], 1);
    wr(3'd1, 8'h80); rd(3'd1, d); chk(d[7] == 1'b0, "R6 clear", d[7], 0);

    // R7 R8 collision and receive-full stall
    arm(8'hA6);
    for (int i = 0; i < 6; i++) wr(3'd2, 8'(i + 1));
    rd(3'd1, d); chk(d[6] == 1'b1, "R7 collision flag", d[6], 1);
    repeat (200) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(3'd2, d); chk(d == 8'hA6, "R8 held byte", d, 8'hA6);
    end
    rd(3'd1, d); chk(d[0] == 1'b1, "R8 fifth pending", d[0], 1);
    got = 0;
    for (int i = 0; i < 6; i++) begin
      repeat (40) @(posedge clk);
      rd(3'd1, d);
      if (!d[0]) begin rd(3'd2, d); got++; end
    end
    chk(got == 1, "R7 R8 bytes after stall", got, 1);
    wr(3'd1, 8'h40); rd(3'd1, d); chk(d[6] == 1'b0, "R6 wcol clear", d[6], 0);

    // R10 abort and flush
    wr(3'd3, 8'h02); wr(3'd0, 8'h43);
    arm(8'h11);
    wr(3'd2, 8'h81); wr(3'd2, 8'h82);
    repeat (100) @(posedge clk);
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h83);
    repeat (3) @(posedge clk);
    #2 chk(sck == 1'b0, "R10 sck rest", sck, 0);
    rd(3'd1, d); chk(d[0] == 1'b1, "R10 rx empty", d[0], 1);
    wr(3'd3, 8'h00); wr(3'd0, 8'h40);
    arm(8'h11);
    repeat (100) @(posedge clk);
    chk(ec == 0, "R10 queue flushed", ec, 0);
    rd(3'd1, d); chk(d[0] == 1'b1, "R10 no transfer", d[0], 1);

    // R11 memory-mapped mode blocks transfers
    wr(3'd4, 8'h01);
    arm(8'h22);
    wr(3'd2, 8'h99);
    repeat (50) @(posedge clk);
    chk(ec == 0, "R11 no sck", ec, 0);
    wr(3'd4, 8'h00);
    repeat (50) @(posedge clk);
    chk(ec == 0, "R11 byte discarded", ec, 0);
    rd(3'd1, d); chk(d[0] == 1'b1, "R11 rx empty", d[0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule